// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits between a serial receiver and its receive FIFO. Every character that the receiver delivers is forwarded to the FIFO one clock later, unchanged. While detection is enabled, the block also compares each character against a programmed special character. A match latches a status flag for the interrupt status register and raises an interrupt request. The matching character stays in the data stream and is never removed from it.

The comparison covers only as many low-order bits as the programmed word length (5 to 8). Bit 0 of the comparison value lines up with the first-received LSB of the character. Characters that arrive with a framing or parity error never count as matches. The host clears the flag by reading the interrupt status register.

Top module: `rx_spec_char_det`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `fifo_wr`, `match_flag` and `irq` are 0.
- R2: When `rx_valid` is high, in the next cycle `fifo_wr` is 1 and `fifo_data` equals that cycle's `rx_data`. This holds whether or not the character matches and whether or not detection is enabled. In cycles without `rx_valid`, `fifo_wr` is 0 in the next cycle.
- R3: Only bits [n-1:0] of `rx_data` and `spec_char` are compared. n is set by `word_len`: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7, and 2'b11 gives 8. Differences in the higher bits do not prevent a match.
- R4: With `det_en` high, a valid error-free character that matches sets `match_flag` in the next cycle.
- R5: A character with `rx_frm_err` or `rx_par_err` high does not set `match_flag`.
- R6: Once set, `match_flag` stays set until a cycle in which `isr_rd` is high; it is 0 in the cycle after. If a new match arrives in the same cycle as `isr_rd`, the flag stays 1.
- R7: With `det_en` low, no match is flagged, and `match_flag` is 0 in the cycle after any cycle with `det_en` low.
- R8: `irq` is high exactly when `match_flag` is high.
- R9: A cycle with `rx_valid` low never sets `match_flag`, whatever `rx_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character, bit 0 first received |
| rx_frm_err | input | 1 | Framing error on this character |
| rx_par_err | input | 1 | Parity error on this character |
| word_len | input | 2 | Word length select: 00=5, 01=6, 10=7, 11=8 bits |
| spec_char | input | 8 | Programmed special character |
| det_en | input | 1 | Special character detection enable |
| isr_rd | input | 1 | Host read of the interrupt status register |
| fifo_wr | output | 1 | Write strobe into the RX FIFO |
| fifo_data | output | 8 | Character written into the RX FIFO |
| match_flag | output | 1 | Special character status bit |
| irq | output | 1 | Interrupt request |

## Verification
The block holds only two pieces of internal state: the forwarded character and the latched flag. Any error in either one therefore shows at the ports on the very next cycle. A wrong comparison mask or a wrong word-length decode shows up as a flag that is missing or spurious one cycle after the strobe. A lost hold or a lost clear shows up as a flag that differs from the model in the cycle after the read or after the hold should have applied. The behavioural model is checked on every clock. This catches both kinds of error within one cycle, across directed corner cases and a long random stream that is dense in near-matches.

// File: rtl/rx_spec_char_det.sv
module rx_spec_char_det #(
  parameter int DW     = 8,
  parameter int WL_MIN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_frm_err,
  input  logic          rx_par_err,
  input  logic [1:0]    word_len,
  input  logic [DW-1:0] spec_char,
  input  logic          det_en,
  input  logic          isr_rd,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          match_flag,
  output logic          irq
);

  localparam int WLW = $bits(word_len);

  logic [DW-1:0] cmp_mask;
  logic          hit;

  always_comb begin
    for (int i = 0; i < DW; i++)
      cmp_mask[i] = (i < WL_MIN + int'(word_len));
  end

  assign hit = det_en && rx_valid && !rx_frm_err && !rx_par_err &&
               (((rx_data ^ spec_char) & cmp_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_data  <= '0;
      match_flag <= 1'b0;
    end else begin
      fifo_wr    <= rx_valid;
      if (rx_valid) fifo_data <= rx_data;
      match_flag <= det_en && (hit || (match_flag && !isr_rd));
    end
  end

  assign irq = match_flag;

  // R2: every strobed character reaches the FIFO port one cycle later
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (fifo_wr && fifo_data == $past(rx_data)));

  // R5, R9: no set from an errored character or from an idle cycle
  a_r5_no_set_from_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag && (!rx_valid || rx_frm_err || rx_par_err)) |=> !match_flag);

  // R6: hold until read
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !isr_rd && det_en) |=> match_flag);

  // R6: a read with no new character clears
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && isr_rd && !rx_valid) |=> !match_flag);

  // R7: disabled detection leaves no flag
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !match_flag);

  // R3: a full-width equal character is always a match
  a_r3_full_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && rx_valid && !rx_frm_err && !rx_par_err && rx_data == spec_char)
      |=> match_flag);

  initial assert (WL_MIN + (1 << WLW) - 1 == DW) else $error("word length span mismatch");

endmodule

// File: tb/tb_rx_spec_char_det.sv
module tb_rx_spec_char_det;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_frm_err = 1'b0;
  logic       rx_par_err = 1'b0;
  logic [1:0] word_len = 2'b11;
  logic [7:0] spec_char = '0;
  logic       det_en = 1'b0;
  logic       isr_rd = 1'b0;
  logic       fifo_wr;
  logic [7:0] fifo_data;
  logic       match_flag;
  logic       irq;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  bit       m_wr = 0;
  bit [7:0] m_data = 0;
  bit       m_flag = 0;

  always #2 clk = ~clk;

  rx_spec_char_det dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .word_len(word_len),
    .spec_char(spec_char), .det_en(det_en), .isr_rd(isr_rd),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .match_flag(match_flag), .irq(irq)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    int  n;
    int  mask;
    bit  m;
    n = 5 + word_len;
    mask = (1 << n) - 1;
    m = det_en && rx_valid && !rx_frm_err && !rx_par_err &&
        ((int'(rx_data) & mask) == (int'(spec_char) & mask));
    if (!rst_n) begin
      m_wr = 0; m_data = 0; m_flag = 0;
    end else begin
      m_wr = rx_valid;
      if (rx_valid) m_data = rx_data;
      if (!det_en) m_flag = 0;
      else if (m) m_flag = 1;
      else if (isr_rd) m_flag = 0;
    end
  end

  task automatic cmp1(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    cmp1("fifo_wr", fifo_wr, m_wr);
    if (m_wr) cmp1("fifo_data R2", fifo_data, m_data);
    cmp1("match_flag", match_flag, m_flag);
    cmp1("irq R8", irq, m_flag);
  endtask

  task automatic put(bit v, bit [7:0] d, bit fe = 0, bit pe = 0, bit rd = 0);
    rx_valid = v; rx_data = d; rx_frm_err = fe; rx_par_err = pe; isr_rd = rd;
    step();
    rx_valid = 0; rx_frm_err = 0; rx_par_err = 0; isr_rd = 0;
  endtask

  initial begin
    // R1 reset state
    tag = "R1";
    rx_valid = 1; rx_data = 8'h15; spec_char = 8'h15; det_en = 1;
    repeat (3) step();
    rx_valid = 0;
    rst_n = 1;
    step();

    // R2 forwarding with detection off and on
    tag = "R2";
    det_en = 0;
    for (int i = 0; i < 6; i++) put(1, 8'(i * 37 + 1));
    det_en = 1; spec_char = 8'hA5;
    put(1, 8'hA5); put(0, 8'h00); put(1, 8'h3C, 0, 0, 1); put(0, 8'hA5);

    // R3 word-length masking
    tag = "R3";
    spec_char = 8'h15;
    word_len = 2'b00; put(1, 8'hF5); put(0, 0, 0, 0, 1); step();
    word_len = 2'b11; put(1, 8'hF5); put(1, 8'h95); step();
    word_len = 2'b01; put(1, 8'hF5); put(1, 8'hD5); put(0, 0, 0, 0, 1); step();
    word_len = 2'b10; put(1, 8'h95); put(0, 0, 0, 0, 1); put(1, 8'h55); step();
    word_len = 2'b11;

    // R4 basic match
    tag = "R4";
    spec_char = 8'h13;
    put(1, 8'h13); step();
    put(0, 0, 0, 0, 1); step();

    // R5 errored characters
    tag = "R5";
    put(1, 8'h13, 1, 0); put(1, 8'h13, 0, 1); put(1, 8'h13, 1, 1); step();

    // R9 matching data without strobe
    tag = "R9";
    put(0, 8'h13); put(0, 8'h13); step();

    // R6 hold, clear, and simultaneous set with read
    tag = "R6";
    put(1, 8'h13);
    repeat (5) step();
    put(0, 0, 0, 0, 1); step();
    put(1, 8'h13); put(1, 8'h13, 0, 0, 1); step();
    put(1, 8'h12, 0, 0, 1); step();

    // R7 disable
    tag = "R7";
    det_en = 0; put(1, 8'h13); step();
    det_en = 1; put(1, 8'h13); step();
    det_en = 0; step(); step();
    det_en = 1; step();

    // R8 and R3 random stream dense in near-matches
    tag = "R8";
    for (int i = 0; i < 400; i++) begin
      word_len = 2'($urandom_range(0, 3));
      det_en = ($urandom_range(0, 9) != 0);
      rx_valid = $urandom_range(0, 1);
      rx_data = spec_char ^ (8'($urandom_range(0, 3)) << $urandom_range(3, 7));
      rx_frm_err = ($urandom_range(0, 7) == 0);
      rx_par_err = ($urandom_range(0, 7) == 0);
      isr_rd = ($urandom_range(0, 3) == 0);
      step();
    end
    rx_valid = 0; isr_rd = 0;
    step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog %s: actual hung expected done", tag);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule